// File: doc/BRIEF.md
# Multiple-Register Load/Store Sequencer

This block moves a group of general registers between a register file and word-addressed memory, one word per memory access. A core hands it one command: a mode, an 8-bit mask that selects among the low registers r0..r7, a base or stack-pointer address, the index of the base register, and one extra flag. For a push the flag adds the link register. For a pop it adds the program counter. The sequencer then walks the mask in the order the mode calls for. It reads the register file before each store, writes the register file on each load, and finally reports the updated base address, whether the core should write that address back, the cycle cost, and an empty-list flag.

The command side is a valid/ready handshake. `cmd_ready` is high only while the block is idle, and a command is taken on the rising edge where both `cmd_valid` and `cmd_ready` are high. The command fields are sampled only on that edge. The memory side is a request/acknowledge pair with valid/ready rules. While `mem_req` is high, the memory may hold off by keeping `mem_ack` low for any number of cycles. The address, write data and direction stay frozen until the cycle in which `mem_ack` is high, and a load takes `mem_rdata` in that same cycle. Results appear with a one-cycle `done` pulse and stay on the result pins until the next command is accepted.

Top module: `ldst_seq`

## Requirements
- R1: In push mode (mode code 00), the link register (register index 14) is stored first at base-4 when the extra flag is set. The selected registers follow from r7 down to r0, each at an address 4 below the previous one.
- R2: After a push, the reported base is base minus 4 times the number of words stored, and writeback is 1.
- R3: In pop mode (mode code 01), the selected registers are loaded from r0 upward, starting at base and stepping by +4. With the extra flag set, the program counter (register index 15) is loaded last. The reported base is base plus 4 times the number of words loaded, and writeback is 1.
- R4: A popped program-counter word is written to the register file with bit 0 cleared. Its original bit 0 is reported on `isa_flag`, with `isa_valid` high. After any other command `isa_valid` and `isa_flag` are 0.
- R5: In store-multiple mode (mode code 10), the selected registers are stored from r0 upward, starting at base and stepping by +4. The extra flag is ignored. The reported base is base plus 4 per word, and writeback is always 1.
- R6: In load-multiple mode (mode code 11), the selected registers are loaded from r0 upward, starting at base and stepping by +4. The reported base is base plus 4 per word. Writeback is 1 only when bit `cmd_base_idx` of the mask is 0.
- R7: A command with no word to move sets `empty_err`, makes no memory access, and reports writeback 0 with the base unchanged. A command has no word to move when the mask is zero and the extra flag is clear or does not apply to the mode.
- R8: The reported cycle count is a fixed base plus every cycle in which `mem_req` was high. The fixed base is 3 for a push, 4 for a push with the link register, 2 for a pop, 5 for a pop with the program counter, 2 for store-multiple and 3 for load-multiple.
- R9: While `mem_req` is high and `mem_ack` is low, the next cycle keeps `mem_req` high with the same address, write data and direction.
- R10: `done` is high for exactly one cycle per command, and the result pins hold their values afterwards.
- R11: `cmd_ready` is high only while the block is idle. A command presented while the block is busy is not taken and does not change the transfer in progress.
- R12: After reset, `cmd_ready` is 1 and `done`, `mem_req` and `rf_wr_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is presented |
| cmd_ready | output | 1 | The block is idle and will take a command |
| cmd_mode | input | 2 | 00 push, 01 pop, 10 store-multiple, 11 load-multiple |
| cmd_list | input | NREG | Register selection mask, bit i selects ri |
| cmd_base | input | AW | Base or stack-pointer address |
| cmd_base_idx | input | $clog2(NREG) | Register number of the base (load-multiple writeback rule) |
| cmd_extra | input | 1 | Push: add link register; pop: add program counter |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = store, 0 = load |
| mem_addr | output | AW | Word address of the access |
| mem_wdata | output | DW | Store data |
| mem_ack | input | 1 | Access completes in this cycle |
| mem_rdata | input | DW | Load data, valid with mem_ack |
| rf_rd_idx | output | 4 | Register file read index |
| rf_rd_data | input | DW | Register file read data (combinational) |
| rf_wr_en | output | 1 | Register file write strobe |
| rf_wr_idx | output | 4 | Register file write index |
| rf_wr_data | output | DW | Register file write data |
| done | output | 1 | One-cycle completion pulse |
| fin_base | output | AW | Updated base address |
| fin_wb | output | 1 | Core should write fin_base to the base register |
| cyc_count | output | CW | Reported cycle cost |
| empty_err | output | 1 | Command had nothing to transfer |
| isa_valid | output | 1 | A program-counter word was popped |
| isa_flag | output | 1 | Bit 0 of the popped program-counter word |

## Verification
The assertions assume the following about the block's neighbours:
- The memory raises `mem_ack` only while `mem_req` is high.
- The register file returns `rf_rd_data` combinationally from `rf_rd_idx`, and a register being stored does not change between its read cycle and the end of its store.
- The command fields are meaningful only on the accepting edge.

The bench's memory model derives its acknowledge from `mem_req` and a per-command wait count, and its register file is written only through `rf_wr_en`. Between commands the bench reloads memory and registers only while the block is idle. It also keeps every address inside its 256-word model, so no access aliases.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

  typedef enum logic [1:0] {
    MD_PUSH = 2'd0,
    MD_POP  = 2'd1,
    MD_STM  = 2'd2,
    MD_LDM  = 2'd3
  } ldst_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_REQ,
    ST_DONE
  } ldst_state_e;

  localparam int unsigned RIDX_W = 4;
  localparam logic [RIDX_W-1:0] IDX_LINK = 4'd14;
  localparam logic [RIDX_W-1:0] IDX_PC   = 4'd15;

  // fixed part of the reported cost, per mode and extra slot
  function automatic logic [2:0] fixed_cost(input ldst_mode_e m, input logic ext);
    case (m)
      MD_PUSH: fixed_cost = ext ? 3'd4 : 3'd3;
      MD_POP:  fixed_cost = ext ? 3'd5 : 3'd2;
      MD_STM:  fixed_cost = 3'd2;
      default: fixed_cost = 3'd3;
    endcase
  endfunction

endpackage

// File: rtl/ldst_pick.sv
// Picks one set bit of a mask; HIGH_FIRST selects the scan direction.
module ldst_pick #(
  parameter int unsigned NREG       = 8,
  parameter bit          HIGH_FIRST = 1'b0,
  parameter int unsigned IW         = $clog2(NREG)
) (
  input  logic [NREG-1:0] mask,
  output logic            found,
  output logic [IW-1:0]   idx
);

  assign found = |mask;

  generate
    if (HIGH_FIRST) begin : g_high
      always_comb begin
        idx = '0;
        for (int i = 0; i < NREG; i++)
          if (mask[i]) idx = IW'(i);
      end
    end else begin : g_low
      always_comb begin
        idx = '0;
        for (int i = NREG - 1; i >= 0; i--)
          if (mask[i]) idx = IW'(i);
      end
    end
  endgenerate

endmodule

// File: rtl/ldst_plan.sv
// Derives everything about a command that is known before the first access.
module ldst_plan
  import ldst_pkg::*;
#(
  parameter int unsigned NREG = 8,
  parameter int unsigned AW   = 32,
  parameter int unsigned IW   = $clog2(NREG),
  parameter int unsigned WW   = $clog2(NREG + 2)
) (
  input  logic [1:0]      mode,
  input  logic [NREG-1:0] list,
  input  logic [AW-1:0]   base,
  input  logic [IW-1:0]   base_idx,
  input  logic            extra,
  output logic            extra_eff,
  output logic            store,
  output logic            empty,
  output logic [AW-1:0]   start_addr,
  output logic [AW-1:0]   fin_addr,
  output logic            wb,
  output logic [2:0]      base_cyc
);

  ldst_mode_e     m;
  logic [WW-1:0]  ones;
  logic [WW-1:0]  words;
  logic [AW-1:0]  span;

  assign m = ldst_mode_e'(mode);

  always_comb begin
    ones = '0;
    for (int i = 0; i < NREG; i++)
      ones = ones + WW'(list[i]);
  end

  assign extra_eff = extra && (m == MD_PUSH || m == MD_POP);
  assign store     = (m == MD_PUSH) || (m == MD_STM);
  assign words     = ones + WW'(extra_eff);
  assign empty     = (words == '0);
  assign span      = AW'({words, 2'b00});

  always_comb begin
    if (m == MD_PUSH) begin
      start_addr = base - AW'(4);
      fin_addr   = base - span;
    end else begin
      start_addr = base;
      fin_addr   = base + span;
    end
  end

  always_comb begin
    if (empty)            wb = 1'b0;
    else if (m == MD_LDM) wb = !list[base_idx];
    else                  wb = 1'b1;
  end

  assign base_cyc = fixed_cost(m, extra_eff);

endmodule

// File: rtl/ldst_seq.sv
module ldst_seq
  import ldst_pkg::*;
#(
  parameter int unsigned NREG        = 8,
  parameter int unsigned DW          = 32,
  parameter int unsigned AW          = 32,
  parameter int unsigned CW          = 16,
  parameter bit          ISA_FROM_PC = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  output logic                     cmd_ready,
  input  logic [1:0]               cmd_mode,
  input  logic [NREG-1:0]          cmd_list,
  input  logic [AW-1:0]            cmd_base,
  input  logic [$clog2(NREG)-1:0]  cmd_base_idx,
  input  logic                     cmd_extra,
  output logic                     mem_req,
  output logic                     mem_we,
  output logic [AW-1:0]            mem_addr,
  output logic [DW-1:0]            mem_wdata,
  input  logic                     mem_ack,
  input  logic [DW-1:0]            mem_rdata,
  output logic [3:0]               rf_rd_idx,
  input  logic [DW-1:0]            rf_rd_data,
  output logic                     rf_wr_en,
  output logic [3:0]               rf_wr_idx,
  output logic [DW-1:0]            rf_wr_data,
  output logic                     done,
  output logic [AW-1:0]            fin_base,
  output logic                     fin_wb,
  output logic [CW-1:0]            cyc_count,
  output logic                     empty_err,
  output logic                     isa_valid,
  output logic                     isa_flag
);

  localparam int unsigned IW = $clog2(NREG);

  // command plan
  logic          pl_extra, pl_store, pl_empty, pl_wb;
  logic [AW-1:0] pl_start, pl_fin;
  logic [2:0]    pl_cyc;

  ldst_plan #(.NREG(NREG), .AW(AW)) u_plan (
    .mode      (cmd_mode),
    .list      (cmd_list),
    .base      (cmd_base),
    .base_idx  (cmd_base_idx),
    .extra     (cmd_extra),
    .extra_eff (pl_extra),
    .store     (pl_store),
    .empty     (pl_empty),
    .start_addr(pl_start),
    .fin_addr  (pl_fin),
    .wb        (pl_wb),
    .base_cyc  (pl_cyc)
  );

  // sequencing state
  ldst_state_e     state_q;
  ldst_mode_e      mode_q;
  logic [NREG-1:0] mask_q, list_q;
  logic [IW-1:0]   bidx_q;
  logic            extra_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wdata_q;
  logic [AW-1:0]   fin_q;
  logic            wb_q;
  logic [CW-1:0]   cnt_q;
  logic            err_q;
  logic            isa_v_q, isa_f_q;

  // slot selection: push scans downward, every other mode upward
  logic          up_found, dn_found;
  logic [IW-1:0] up_idx, dn_idx;

  ldst_pick #(.NREG(NREG), .HIGH_FIRST(1'b0)) u_pick_up (
    .mask(mask_q), .found(up_found), .idx(up_idx)
  );
  ldst_pick #(.NREG(NREG), .HIGH_FIRST(1'b1)) u_pick_dn (
    .mask(mask_q), .found(dn_found), .idx(dn_idx)
  );

  logic              is_push, store_q, use_extra, more, accept, pc_hit;
  logic [IW-1:0]     sel_lidx;
  logic [RIDX_W-1:0] slot_idx;
  logic [NREG-1:0]   mask_nxt;
  logic              extra_nxt;

  assign is_push = (mode_q == MD_PUSH);
  assign store_q = (mode_q == MD_PUSH) || (mode_q == MD_STM);

  always_comb begin
    if (is_push) begin
      use_extra = extra_q;
      sel_lidx  = dn_idx;
      slot_idx  = extra_q ? IDX_LINK : RIDX_W'(dn_idx);
    end else begin
      use_extra = extra_q && !up_found;
      sel_lidx  = up_idx;
      slot_idx  = use_extra ? IDX_PC : RIDX_W'(up_idx);
    end
  end

  assign mask_nxt  = use_extra ? mask_q : (mask_q & ~(NREG'(1) << sel_lidx));
  assign extra_nxt = use_extra ? 1'b0 : extra_q;
  assign more      = (|mask_nxt) || extra_nxt;
  assign accept    = cmd_valid && cmd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= MD_PUSH;
      mask_q  <= '0;
      list_q  <= '0;
      bidx_q  <= '0;
      extra_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      fin_q   <= '0;
      wb_q    <= 1'b0;
      cnt_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (cmd_valid) begin
            mode_q  <= ldst_mode_e'(cmd_mode);
            mask_q  <= cmd_list;
            list_q  <= cmd_list;
            bidx_q  <= cmd_base_idx;
            extra_q <= pl_extra;
            addr_q  <= pl_start;
            fin_q   <= pl_fin;
            wb_q    <= pl_wb;
            cnt_q   <= CW'(pl_cyc);
            err_q   <= pl_empty;
            if (pl_empty)      state_q <= ST_DONE;
            else if (pl_store) state_q <= ST_FETCH;
            else               state_q <= ST_REQ;
          end
        end
        ST_FETCH: begin
          wdata_q <= rf_rd_data;
          state_q <= ST_REQ;
        end
        ST_REQ: begin
          cnt_q <= cnt_q + CW'(1);
          if (mem_ack) begin
            mask_q  <= mask_nxt;
            extra_q <= extra_nxt;
            addr_q  <= is_push ? (addr_q - AW'(4)) : (addr_q + AW'(4));
            if (!more)        state_q <= ST_DONE;
            else if (store_q) state_q <= ST_FETCH;
            else              state_q <= ST_REQ;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // popped program counter may carry the instruction-set state in bit 0
  assign pc_hit = (state_q == ST_REQ) && mem_ack && !store_q && (slot_idx == IDX_PC);

  generate
    if (ISA_FROM_PC) begin : g_isa
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          isa_v_q <= 1'b0;
          isa_f_q <= 1'b0;
        end else if (accept) begin
          isa_v_q <= 1'b0;
          isa_f_q <= 1'b0;
        end else if (pc_hit) begin
          isa_v_q <= 1'b1;
          isa_f_q <= mem_rdata[0];
        end
      end
    end else begin : g_no_isa
      assign isa_v_q = 1'b0;
      assign isa_f_q = 1'b0;
    end
  endgenerate

  // ports
  assign cmd_ready  = (state_q == ST_IDLE);
  assign mem_req    = (state_q == ST_REQ);
  assign mem_we     = store_q;
  assign mem_addr   = addr_q;
  assign mem_wdata  = wdata_q;
  assign rf_rd_idx  = slot_idx;
  assign rf_wr_en   = (state_q == ST_REQ) && mem_ack && !store_q;
  assign rf_wr_idx  = slot_idx;
  assign rf_wr_data = (slot_idx == IDX_PC) ? {mem_rdata[DW-1:1], 1'b0} : mem_rdata;
  assign done       = (state_q == ST_DONE);
  assign fin_base   = fin_q;
  assign fin_wb     = wb_q;
  assign cyc_count  = cnt_q;
  assign empty_err  = err_q;
  assign isa_valid  = isa_v_q;
  assign isa_flag   = isa_f_q;

  // assertion support: the address of the previous completed access
  logic [AW-1:0] last_addr_q;
  logic          seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_addr_q <= '0;
      seen_q      <= 1'b0;
    end else if (accept) begin
      seen_q <= 1'b0;
    end else if (mem_req && mem_ack) begin
      last_addr_q <= mem_addr;
      seen_q      <= 1'b1;
    end
  end

  // R1 R3 R5 R6: consecutive accesses step by one word in the mode's direction
  p_addr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && seen_q |->
      mem_addr == (is_push ? last_addr_q - AW'(4) : last_addr_q + AW'(4)));

  p_hold_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=>
      mem_req && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && $stable(fin_base) && $stable(cyc_count));

  p_ready_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !mem_req && !done && !rf_wr_en);

  p_empty_skip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept && pl_empty |=> done && empty_err && !fin_wb);

  p_ldm_wb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done && mode_q == MD_LDM && list_q[bidx_q] |-> !fin_wb);

  p_pc_even_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_en && rf_wr_idx == IDX_PC |-> !rf_wr_data[0]);

endmodule

// File: tb/test_ldst_seq.sv
`timescale 1ns/1ps
module test_ldst_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_mode = '0;
  logic [7:0]  cmd_list = '0;
  logic [31:0] cmd_base = '0;
  logic [2:0]  cmd_base_idx = '0;
  logic        cmd_extra = 1'b0;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  rf_rd_idx, rf_wr_idx;
  logic [31:0] rf_rd_data, rf_wr_data;
  logic        rf_wr_en, done, fin_wb, empty_err, isa_valid, isa_flag;
  logic [31:0] fin_base;
  logic [15:0] cyc_count;

  always #2.5 clk = ~clk;

  ldst_seq i_ldst_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_mode(cmd_mode),
    .cmd_list(cmd_list), .cmd_base(cmd_base), .cmd_base_idx(cmd_base_idx),
    .cmd_extra(cmd_extra),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
    .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
    .done(done), .fin_base(fin_base), .fin_wb(fin_wb), .cyc_count(cyc_count),
    .empty_err(empty_err), .isa_valid(isa_valid), .isa_flag(isa_flag)
  );

  // memory and register file models
  logic [31:0] mem [256];
  logic [31:0] rf  [16];
  logic [1:0]  lat_cur = '0;
  logic [1:0]  wcnt = '0;
  logic [31:0] log_addr [16];
  logic [3:0]  log_idx  [16];
  int          log_n = 0;
  int          unstable = 0;
  logic        prev_wait = 1'b0;
  logic [31:0] prev_addr = '0, prev_data = '0;

  assign mem_ack    = mem_req && (wcnt == lat_cur);
  assign mem_rdata  = mem[mem_addr[9:2]];
  assign rf_rd_data = rf[rf_rd_idx];

  always @(posedge clk) begin
    prev_wait <= mem_req && !mem_ack;
    prev_addr <= mem_addr;
    prev_data <= mem_wdata;
    if (prev_wait && (!mem_req || mem_addr != prev_addr || mem_wdata != prev_data))
      unstable <= unstable + 1;
    if (mem_req) begin
      if (mem_ack) begin
        wcnt <= '0;
        if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
        if (log_n < 16) begin
          log_addr[log_n] <= mem_addr;
          log_idx[log_n]  <= rf_wr_en ? rf_wr_idx : 4'd0;
        end
        log_n <= log_n + 1;
      end else begin
        wcnt <= wcnt + 2'd1;
      end
    end
    if (rf_wr_en) rf[rf_wr_idx] <= rf_wr_data;
  end

  // bookkeeping
  int checks = 0;
  int failures = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_pat(input logic [31:0] a);
    return 32'hB000_0000 | {24'h0, a[9:2]};
  endfunction

  function automatic logic [31:0] rf_pat(input int r);
    return 32'hA5A5_0000 | (r * 32'h101);
  endfunction

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL R10 watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // stimulus / expected-result table
  typedef struct packed {
    logic [1:0]  mode;
    logic [7:0]  list;
    logic [31:0] base;
    logic [2:0]  bidx;
    logic        extra;
    logic [1:0]  lat;
    logic [31:0] fin;
    logic        wb;
    logic [15:0] cnt;
    logic        err;
    logic [1:0]  isa;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 8'h85, 32'h200, 3'd0, 1'b1, 2'd0, 32'h1F0, 1'b1, 16'd8,  1'b0, 2'b00},
    '{2'd0, 8'hFF, 32'h300, 3'd0, 1'b0, 2'd1, 32'h2E0, 1'b1, 16'd19, 1'b0, 2'b00},
    '{2'd1, 8'h12, 32'h104, 3'd0, 1'b1, 2'd0, 32'h110, 1'b1, 16'd8,  1'b0, 2'b11},
    '{2'd1, 8'h01, 32'h080, 3'd0, 1'b0, 2'd2, 32'h084, 1'b1, 16'd5,  1'b0, 2'b00},
    '{2'd2, 8'h63, 32'h040, 3'd5, 1'b0, 2'd0, 32'h050, 1'b1, 16'd6,  1'b0, 2'b00},
    '{2'd3, 8'h0E, 32'h060, 3'd2, 1'b0, 2'd1, 32'h06C, 1'b0, 16'd9,  1'b0, 2'b00},
    '{2'd3, 8'h81, 32'h0A0, 3'd3, 1'b0, 2'd0, 32'h0A8, 1'b1, 16'd5,  1'b0, 2'b00},
    '{2'd2, 8'h00, 32'h020, 3'd0, 1'b0, 2'd0, 32'h020, 1'b0, 16'd2,  1'b1, 2'b00},
    '{2'd1, 8'h00, 32'h100, 3'd0, 1'b0, 2'd0, 32'h100, 1'b0, 16'd2,  1'b1, 2'b00},
    '{2'd0, 8'h00, 32'h010, 3'd0, 1'b1, 2'd0, 32'h00C, 1'b1, 16'd5,  1'b0, 2'b00},
    '{2'd1, 8'h00, 32'h00C, 3'd0, 1'b1, 2'd3, 32'h010, 1'b1, 16'd9,  1'b0, 2'b11},
    '{2'd2, 8'h10, 32'h0F0, 3'd0, 1'b1, 2'd0, 32'h0F4, 1'b1, 16'd3,  1'b0, 2'b00}
  };

  // expected transfer sequence, built from the ordering requirements
  int          e_n;
  int          e_idx  [16];
  logic [31:0] e_addr [16];

  task automatic build_seq(input vec_t v);
    logic [31:0] a;
    e_n = 0;
    if (v.mode == 2'd0) begin
      a = v.base - 32'd4;
      if (v.extra) begin e_idx[e_n] = 14; e_addr[e_n] = a; e_n++; a -= 32'd4; end
      for (int i = 7; i >= 0; i--)
        if (v.list[i]) begin e_idx[e_n] = i; e_addr[e_n] = a; e_n++; a -= 32'd4; end
    end else begin
      a = v.base;
      for (int i = 0; i < 8; i++)
        if (v.list[i]) begin e_idx[e_n] = i; e_addr[e_n] = a; e_n++; a += 32'd4; end
      if (v.mode == 2'd1 && v.extra) begin e_idx[e_n] = 15; e_addr[e_n] = a; e_n++; end
    end
  endtask

  task automatic load_models();
    for (int w = 0; w < 256; w++) mem[w] <= mem_pat(32'(w) << 2);
    for (int r = 0; r < 16; r++)  rf[r]  <= rf_pat(r);
  endtask

  task automatic wait_done();
    int g = 0;
    while (!done && g < 2000) begin @(negedge clk); g++; end
    if (!done) begin
      failures++;
      $display("FAIL R10 no done pulse actual=0 expected=1");
    end
  endtask

  task automatic run_vec(input vec_t v, input int n);
    string ot;
    @(negedge clk);
    load_models();
    lat_cur = v.lat;
    log_n = 0;
    @(negedge clk);
    cmd_mode = v.mode; cmd_list = v.list; cmd_base = v.base;
    cmd_base_idx = v.bidx; cmd_extra = v.extra; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_done();
    build_seq(v);
    case (v.mode)
      2'd0: ot = "R1";
      2'd1: ot = "R3";
      2'd2: ot = "R5";
      default: ot = "R6";
    endcase
    chk($sformatf("%s/R2 fin_base v%0d", ot, n), fin_base, v.fin);
    chk($sformatf("%s writeback v%0d", ot, n), 32'(fin_wb), 32'(v.wb));
    chk($sformatf("R8 cycle count v%0d", n), 32'(cyc_count), 32'(v.cnt));
    chk($sformatf("R7 empty flag v%0d", n), 32'(empty_err), 32'(v.err));
    chk($sformatf("R4 isa valid/flag v%0d", n), 32'({isa_valid, isa_flag}), 32'(v.isa));
    chk($sformatf("%s/R7 access count v%0d", ot, n), 32'(log_n), 32'(e_n));
    for (int k = 0; k < e_n && k < log_n; k++) begin
      chk($sformatf("%s address k%0d v%0d", ot, k, n), log_addr[k], e_addr[k]);
      if (v.mode == 2'd0 || v.mode == 2'd2)
        chk($sformatf("%s stored data k%0d v%0d", ot, k, n), mem[e_addr[k][9:2]], rf_pat(e_idx[k]));
      else begin
        chk($sformatf("%s load index k%0d v%0d", ot, k, n), 32'(log_idx[k]), 32'(e_idx[k]));
        chk($sformatf("%s/R4 loaded value k%0d v%0d", ot, k, n), rf[e_idx[k]],
            (e_idx[k] == 15) ? (mem_pat(e_addr[k]) & ~32'd1) : mem_pat(e_addr[k]));
      end
    end
    chk($sformatf("R9 stable while waiting v%0d", n), 32'(unstable), 32'd0);
    @(negedge clk);
    chk($sformatf("R10 done single cycle v%0d", n), 32'(done), 32'd0);
    chk($sformatf("R10 result held v%0d", n), fin_base, v.fin);
    chk($sformatf("R11 ready after done v%0d", n), 32'(cmd_ready), 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12 ready in reset", 32'(cmd_ready), 32'd1);
    chk("R12 done in reset", 32'(done), 32'd0);
    chk("R12 mem_req in reset", 32'(mem_req), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 idle after reset", 32'({cmd_ready, done, mem_req, rf_wr_en}), 32'b1000);

    for (int n = 0; n < NV; n++) run_vec(VECS[n], n);

    // R11: a command offered while busy is not taken
    @(negedge clk);
    load_models();
    lat_cur = 2'd3;
    log_n = 0;
    @(negedge clk);
    cmd_mode = 2'd0; cmd_list = 8'h0F; cmd_base = 32'h200;
    cmd_base_idx = 3'd0; cmd_extra = 1'b0; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_mode = 2'd3; cmd_list = 8'hFF; cmd_base = 32'h000; cmd_extra = 1'b1;
    for (int t = 0; t < 3; t++) begin
      chk("R11 ready low while busy", 32'(cmd_ready), 32'd0);
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    wait_done();
    chk("R11 busy command ignored fin_base", fin_base, 32'h1F0);
    chk("R11 busy command ignored count", 32'(cyc_count), 32'd19);
    chk("R11 busy command ignored accesses", 32'(log_n), 32'd4);
    chk("R11 busy command ignored first addr", log_addr[0], 32'h1FC);
    chk("R11 busy command ignored store", mem[8'h7C], rf_pat(0));
    @(negedge clk);
    chk("R10 busy run done single cycle", 32'(done), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule